// File: doc/BRIEF.md
# Packet page allocator

This block tracks a small pool of fixed-size packet buffer pages for a network controller. It does not store packet data. It keeps a busy mask with one bit per page and hands out the lowest free page when a transmit allocation is requested. It also keeps two page-number FIFOs: a receive queue of pages holding frames that have arrived, and a transmit-completion queue of pages whose frames have gone out.

A host writes command bytes. The top three bits of each byte select a memory-management operation and the low five bits are ignored. One operation allocates a page for transmit. Others reset all bookkeeping, drop the head of the receive queue, or drop that head and also free its page. When a transmit allocation finds no free page, the result register holds a failure code and the request stays pending. The next page release completes the request automatically and raises the allocation-done status bit.

Pages are freed through a dedicated release port or by the pop-and-free command. A release and a command in the same cycle are applied in that order. Every result becomes visible one clock after the stimulus.

Top module: `page_alloc_mmu`

## Requirements
- R1: `page_busy` has one bit per page and is all zero after reset. A busy bit clears only through `rel_valid`, command 4 or command 2.
- R2: Command 1 (`cmd_byte[7:5]==1`) grants the lowest-numbered free page. On the next cycle `alloc_result` holds that page number in its low bits with bit 7 clear, and the page's busy bit is set.
- R3: If command 1 finds every page busy, `alloc_result` reads 8'h80 and `alloc_pending` goes high on the next cycle.
- R4: Command 1 clears `irq_alloc` when it is issued. Any successful grant sets `irq_alloc`.
- R5: While `alloc_pending` is high, any release (`rel_valid` or command 4) retries the allocation. The retry grants the lowest free page, sets `irq_alloc` and clears `alloc_pending`. A release in the same cycle as command 1 is applied before the allocation attempt.
- R6: Command 2 clears the busy mask, both FIFOs, `alloc_pending`, `irq_rx` and `rx_overflow`, and sets `alloc_result` to 0. `irq_alloc` is left unchanged, and pushes in that cycle are discarded.
- R7: Commands 3 and 4 remove the receive queue head, and the remaining entries move one place toward the head. After any pop or accepted push, `irq_rx` is 1 if the queue is non-empty and 0 if it is empty. A pop of an empty queue is ignored. `rx_head` reads 0 when the queue is empty.
- R8: Command 4 on a non-empty receive queue also frees the page number that was at its head.
- R9: The receive queue holds `FIFO_DEPTH` (4) entries. A push that finds it full, after any same-cycle pop, is dropped and sets the sticky `rx_overflow` flag.
- R10: The transmit-completion queue holds 4 entries and applies a pop before a push in the same cycle. A pop of an empty queue is ignored, a push into a full queue is dropped, and `txd_head` reads 0 when the queue is empty.
- R11: Command codes 0, 5, 6 and 7, and any cycle with `cmd_wr` low, leave the busy mask, result, pending state and receive queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte; bits 7:5 are the operation code |
| rel_valid | input | 1 | Release request for `rel_page` |
| rel_page | input | PW (2) | Page number to free |
| rx_push | input | 1 | Append `rx_page` to the receive queue |
| rx_page | input | PW (2) | Page number of a received frame |
| txd_push | input | 1 | Append `txd_page` to the transmit-completion queue |
| txd_page | input | PW (2) | Page number of a finished transmit |
| txd_pop | input | 1 | Remove the transmit-completion queue head |
| alloc_result | output | 8 | Granted page number, or 8'h80 on failure |
| alloc_pending | output | 1 | A failed allocation is waiting for a release |
| page_busy | output | NUM_PAGES (4) | Allocated-page mask |
| irq_alloc | output | 1 | Allocation-done status |
| irq_rx | output | 1 | Receive-pending status |
| rx_head | output | PW (2) | Receive queue head page |
| rx_count | output | CW (3) | Receive queue occupancy |
| rx_overflow | output | 1 | Sticky receive push-drop flag |
| txd_head | output | PW (2) | Transmit-completion queue head page |
| txd_count | output | CW (3) | Transmit-completion queue occupancy |

## Verification
The assertions assume that at most one command is presented per cycle. They also assume that page numbers on the release and push ports lie inside the pool, which holds trivially when the pool size is a power of two. Releasing a page that is already free is treated as harmless, and such a release still counts as the event that wakes a pending allocation. The random phase keeps every page index within the pool and still releases free pages. It weights the MMU reset low, so the pool fills up, allocations fail and pend, and both queues reach their full and empty limits between resets.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;

  typedef enum logic [2:0] {
    MMU_NOP         = 3'd0,
    MMU_ALLOC_TX    = 3'd1,
    MMU_RESET       = 3'd2,
    MMU_RX_POP      = 3'd3,
    MMU_RX_POP_FREE = 3'd4,
    MMU_RSVD5       = 3'd5,
    MMU_RSVD6       = 3'd6,
    MMU_RSVD7       = 3'd7
  } mmu_op_e;

  localparam logic [7:0] ALLOC_FAIL_CODE = 8'h80;

  // Operation code sits in the top three bits of the command byte.
  function automatic mmu_op_e decode_op(input logic wr, input logic [7:0] cmd);
    return wr ? mmu_op_e'(cmd[7:5]) : MMU_NOP;
  endfunction

endpackage

// File: rtl/page_fifo.sv
module page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level,
  output logic          pop_ok,
  output logic          push_ok,
  output logic          push_drop
);

  logic [DEPTH-1:0][W-1:0] slot_q;
  logic [DEPTH-1:0][W-1:0] slot_d;
  logic [CW-1:0]           lvl_q;
  logic [CW-1:0]           lvl_mid;

  // Occupancy once a granted pop has been taken out.
  function automatic logic [CW-1:0] after_pop(input logic [CW-1:0] n, input logic p);
    return n - CW'(p);
  endfunction

  assign pop_ok    = pop && (lvl_q != '0);
  assign lvl_mid   = after_pop(lvl_q, pop_ok);
  assign push_ok   = push && (lvl_mid < CW'(DEPTH));
  assign push_drop = push && !push_ok;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] shifted;
    if (g < DEPTH - 1) begin : g_mid
      assign shifted = slot_q[g+1];
    end else begin : g_last
      assign shifted = slot_q[g];
    end
    assign slot_d[g] = (push_ok && (lvl_mid == CW'(g))) ? din :
                       pop_ok                           ? shifted :
                                                          slot_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      lvl_q  <= '0;
    end else if (clr) begin
      lvl_q  <= '0;
    end else begin
      slot_q <= slot_d;
      lvl_q  <= lvl_mid + CW'(push_ok);
    end
  end

  assign head  = (lvl_q != '0) ? slot_q[0] : '0;
  assign level = lvl_q;

endmodule

// File: rtl/page_pool.sv
module page_pool
  import page_alloc_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 req,
  input  logic [NUM_PAGES-1:0] rel_mask,
  output logic [NUM_PAGES-1:0] busy,
  output logic [7:0]           result,
  output logic                 pending,
  output logic                 irq,
  output logic                 grant,
  output logic                 fail
);

  logic [NUM_PAGES-1:0] busy_q;
  logic [NUM_PAGES-1:0] busy_mid;
  logic [7:0]           result_q;
  logic                 pend_q;
  logic                 irq_q;
  logic                 attempt;
  logic                 has_free;
  logic [PW-1:0]        pick;

  // Lowest index whose busy bit is clear.
  function automatic logic [PW-1:0] lowest_free(input logic [NUM_PAGES-1:0] m);
    logic [PW-1:0] idx;
    idx = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!m[i]) idx = PW'(i);
    end
    return idx;
  endfunction

  // Releases are applied before any allocation attempt.
  assign busy_mid = busy_q & ~rel_mask;
  assign attempt  = req || (pend_q && (rel_mask != '0));
  assign has_free = !(&busy_mid);
  assign pick     = lowest_free(busy_mid);
  assign grant    = attempt && has_free && !clr;
  assign fail     = req && !has_free && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      result_q <= '0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else if (clr) begin
      busy_q   <= '0;
      result_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      busy_q <= busy_mid | (grant ? (NUM_PAGES'(1) << pick) : '0);
      if (grant) begin
        result_q <= 8'(pick);
        pend_q   <= 1'b0;
        irq_q    <= 1'b1;
      end else if (fail) begin
        result_q <= ALLOC_FAIL_CODE;
        pend_q   <= 1'b1;
        irq_q    <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign result  = result_q;
  assign pending = pend_q;
  assign irq     = irq_q;

endmodule

// File: rtl/page_alloc_mmu.sv
module page_alloc_mmu
  import page_alloc_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int PW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [7:0]           cmd_byte,
  input  logic                 rel_valid,
  input  logic [PW-1:0]        rel_page,
  input  logic                 rx_push,
  input  logic [PW-1:0]        rx_page,
  input  logic                 txd_push,
  input  logic [PW-1:0]        txd_page,
  input  logic                 txd_pop,
  output logic [7:0]           alloc_result,
  output logic                 alloc_pending,
  output logic [NUM_PAGES-1:0] page_busy,
  output logic                 irq_alloc,
  output logic                 irq_rx,
  output logic [PW-1:0]        rx_head,
  output logic [CW-1:0]        rx_count,
  output logic                 rx_overflow,
  output logic [PW-1:0]        txd_head,
  output logic [CW-1:0]        txd_count
);

  mmu_op_e              cur_op;
  logic                 mmu_clr;
  logic                 alloc_req;
  logic                 rx_pop_req;
  logic                 rx_free_req;
  logic [NUM_PAGES-1:0] rel_mask;
  logic                 alloc_grant;
  logic                 alloc_fail;
  logic                 rx_pop_ok;
  logic                 rx_push_ok;
  logic                 rx_drop;
  logic                 txd_pop_ok;
  logic                 txd_push_ok;
  logic                 txd_drop;
  logic [CW-1:0]        rx_level_nxt;
  logic                 irq_rx_q;
  logic                 rx_ovf_q;

  function automatic logic [NUM_PAGES-1:0] page_bit(input logic [PW-1:0] p);
    return NUM_PAGES'(1) << p;
  endfunction

  function automatic logic [CW-1:0] level_after(input logic [CW-1:0] n,
                                                input logic p, input logic q);
    return n - CW'(p) + CW'(q);
  endfunction

  assign cur_op      = decode_op(cmd_wr, cmd_byte);
  assign mmu_clr     = (cur_op == MMU_RESET);
  assign alloc_req   = (cur_op == MMU_ALLOC_TX);
  assign rx_pop_req  = (cur_op == MMU_RX_POP) || (cur_op == MMU_RX_POP_FREE);
  assign rx_free_req = (cur_op == MMU_RX_POP_FREE) && (rx_count != '0);

  assign rel_mask = (rel_valid   ? page_bit(rel_page) : '0)
                  | (rx_free_req ? page_bit(rx_head)  : '0);

  page_pool #(.NUM_PAGES(NUM_PAGES)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mmu_clr),
    .req      (alloc_req),
    .rel_mask (rel_mask),
    .busy     (page_busy),
    .result   (alloc_result),
    .pending  (alloc_pending),
    .irq      (irq_alloc),
    .grant    (alloc_grant),
    .fail     (alloc_fail)
  );

  page_fifo #(.DEPTH(FIFO_DEPTH), .W(PW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mmu_clr),
    .pop       (rx_pop_req),
    .push      (rx_push),
    .din       (rx_page),
    .head      (rx_head),
    .level     (rx_count),
    .pop_ok    (rx_pop_ok),
    .push_ok   (rx_push_ok),
    .push_drop (rx_drop)
  );

  page_fifo #(.DEPTH(FIFO_DEPTH), .W(PW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mmu_clr),
    .pop       (txd_pop),
    .push      (txd_push),
    .din       (txd_page),
    .head      (txd_head),
    .level     (txd_count),
    .pop_ok    (txd_pop_ok),
    .push_ok   (txd_push_ok),
    .push_drop (txd_drop)
  );

  assign rx_level_nxt = level_after(rx_count, rx_pop_ok, rx_push_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else if (mmu_clr) begin
      irq_rx_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else begin
      if (rx_pop_ok || rx_push_ok) irq_rx_q <= (rx_level_nxt != '0);
      if (rx_drop)                 rx_ovf_q <= 1'b1;
    end
  end

  assign irq_rx      = irq_rx_q;
  assign rx_overflow = rx_ovf_q;

endmodule

// File: rtl/page_alloc_mmu_chk.sv
module page_alloc_mmu_chk #(
  parameter int NUM_PAGES  = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int PW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cur_op,
  input logic                 rel_valid,
  input logic                 txd_push,
  input logic                 txd_pop,
  input logic [7:0]           alloc_result,
  input logic                 alloc_pending,
  input logic [NUM_PAGES-1:0] page_busy,
  input logic                 irq_alloc,
  input logic [CW-1:0]        rx_count,
  input logic                 rx_overflow,
  input logic [CW-1:0]        txd_count,
  input logic                 alloc_grant,
  input logic                 alloc_fail,
  input logic                 txd_drop,
  input logic                 txd_pop_ok,
  input logic                 txd_push_ok
);

  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_valid && cur_op != 3'd2 && cur_op != 3'd4)
      |=> ((page_busy & $past(page_busy)) == $past(page_busy))); // R1

  AST_GRANT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> (!alloc_result[7] && page_busy[alloc_result[PW-1:0]])); // R2

  AST_FAIL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fail |=> (alloc_result == 8'h80 && alloc_pending)); // R3

  AST_ALLOC_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == 3'd1 && (&page_busy) && !rel_valid) |=> !irq_alloc); // R4

  AST_GRANT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |=> (irq_alloc && !alloc_pending)); // R5

  AST_MMU_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == 3'd2) |=> (page_busy == '0 && rx_count == '0 && txd_count == '0
                          && !alloc_pending && !rx_overflow)); // R6

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(FIFO_DEPTH)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && cur_op != 3'd2) |=> rx_overflow); // R9

  AST_TXD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    txd_count <= CW'(FIFO_DEPTH)); // R10

  AST_TXD_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    txd_drop |-> (txd_count == CW'(FIFO_DEPTH) && !txd_pop_ok)); // R10

  AST_TXD_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_pop && !txd_push && txd_count == '0) |=> txd_count == '0); // R10

  AST_TXD_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_pop_ok && !txd_push_ok && cur_op != 3'd2)
      |=> txd_count == $past(txd_count) - CW'(1)); // R10

  AST_TXD_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_push_ok && !txd_pop_ok && cur_op != 3'd2)
      |=> txd_count == $past(txd_count) + CW'(1)); // R10

  AST_RSVD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op >= 3'd5 && !rel_valid)
      |=> (page_busy == $past(page_busy) && alloc_result == $past(alloc_result))); // R11

endmodule

bind page_alloc_mmu page_alloc_mmu_chk #(
  .NUM_PAGES  (NUM_PAGES),
  .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cur_op        (cur_op),
  .rel_valid     (rel_valid),
  .txd_push      (txd_push),
  .txd_pop       (txd_pop),
  .alloc_result  (alloc_result),
  .alloc_pending (alloc_pending),
  .page_busy     (page_busy),
  .irq_alloc     (irq_alloc),
  .rx_count      (rx_count),
  .rx_overflow   (rx_overflow),
  .txd_count     (txd_count),
  .alloc_grant   (alloc_grant),
  .alloc_fail    (alloc_fail),
  .txd_drop      (txd_drop),
  .txd_pop_ok    (txd_pop_ok),
  .txd_push_ok   (txd_push_ok)
);

// File: tb/page_alloc_mmu_tb.sv
module page_alloc_mmu_tb;
  localparam int NP = 4;
  localparam int FD = 4;
  localparam int PW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cmd_wr = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic          rel_valid = 1'b0;
  logic [PW-1:0] rel_page = '0;
  logic          rx_push = 1'b0;
  logic [PW-1:0] rx_page = '0;
  logic          txd_push = 1'b0;
  logic [PW-1:0] txd_page = '0;
  logic          txd_pop = 1'b0;

  logic [7:0]    alloc_result;
  logic          alloc_pending;
  logic [NP-1:0] page_busy;
  logic          irq_alloc;
  logic          irq_rx;
  logic [PW-1:0] rx_head;
  logic [CW-1:0] rx_count;
  logic          rx_overflow;
  logic [PW-1:0] txd_head;
  logic [CW-1:0] txd_count;

  page_alloc_mmu #(.NUM_PAGES(NP), .FIFO_DEPTH(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .rel_valid(rel_valid), .rel_page(rel_page), .rx_push(rx_push), .rx_page(rx_page),
    .txd_push(txd_push), .txd_page(txd_page), .txd_pop(txd_pop),
    .alloc_result(alloc_result), .alloc_pending(alloc_pending), .page_busy(page_busy),
    .irq_alloc(irq_alloc), .irq_rx(irq_rx), .rx_head(rx_head), .rx_count(rx_count),
    .rx_overflow(rx_overflow), .txd_head(txd_head), .txd_count(txd_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_busy, m_res;
  bit m_pend, m_airq, m_rxirq, m_ovf;
  int rxq[$];
  int txq[$];

  task automatic model_reset();
    m_busy = 0; m_res = 0; m_pend = 0; m_airq = 0; m_rxirq = 0; m_ovf = 0;
    rxq.delete(); txq.delete();
  endtask

  task automatic model_step();
    int op, relm;
    bit tried, popped, pushed;
    op = cmd_wr ? int'(cmd_byte[7:5]) : 0;
    if (op == 2) begin
      m_busy = 0; m_pend = 0; m_res = 0; m_rxirq = 0; m_ovf = 0;
      rxq.delete(); txq.delete();
      return;
    end
    relm = rel_valid ? (1 << rel_page) : 0;
    if (op == 4 && rxq.size() > 0) relm |= (1 << rxq[0]);
    m_busy &= ~relm;
    tried = (op == 1) || (m_pend && relm != 0);
    if (op == 1) m_airq = 0;
    if (tried) begin
      int pick = -1;
      for (int i = NP - 1; i >= 0; i--) if (((m_busy >> i) & 1) == 0) pick = i;
      if (pick >= 0) begin
        m_busy |= (1 << pick); m_res = pick; m_pend = 0; m_airq = 1;
      end else if (op == 1) begin
        m_res = 128; m_pend = 1;
      end
    end
    popped = 0; pushed = 0;
    if ((op == 3 || op == 4) && rxq.size() > 0) begin
      void'(rxq.pop_front()); popped = 1;
    end
    if (rx_push) begin
      if (rxq.size() < FD) begin rxq.push_back(int'(rx_page)); pushed = 1; end
      else m_ovf = 1;
    end
    if (popped || pushed) m_rxirq = (rxq.size() != 0);
    if (txd_pop && txq.size() > 0) void'(txq.pop_front());
    if (txd_push && txq.size() < FD) txq.push_back(int'(txd_page));
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 page_busy", int'(page_busy), m_busy);
      chk("R2 alloc_result", int'(alloc_result), m_res);
      chk("R3 alloc_pending", int'(alloc_pending), int'(m_pend));
      chk("R4 irq_alloc", int'(irq_alloc), int'(m_airq));
      chk("R7 rx_head", int'(rx_head), rxq.size() > 0 ? rxq[0] : 0);
      chk("R7 rx_count", int'(rx_count), rxq.size());
      chk("R7 irq_rx", int'(irq_rx), int'(m_rxirq));
      chk("R9 rx_overflow", int'(rx_overflow), int'(m_ovf));
      chk("R10 txd_head", int'(txd_head), txq.size() > 0 ? txq[0] : 0);
      chk("R10 txd_count", int'(txd_count), txq.size());
    end
  end

  task automatic drive(bit cw, logic [7:0] cb, bit rv = 0, int rp = 0, bit rxp = 0,
                       int rxpg = 0, bit tp = 0, int tpg = 0, bit tpop = 0);
    @(negedge clk);
    cmd_wr = cw; cmd_byte = cb; rel_valid = rv; rel_page = PW'(rp);
    rx_push = rxp; rx_page = PW'(rxpg); txd_push = tp; txd_page = PW'(tpg); txd_pop = tpop;
  endtask

  task automatic idle();
    drive(0, 8'h00);
  endtask

  function automatic logic [7:0] mk(int op);
    return {3'(op), 5'b10101};
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset busy", int'(page_busy), 0);
    chk("R6 reset result", int'(alloc_result), 0);
    chk("R7 reset rx_count", int'(rx_count), 0);

    // R2: four grants in ascending order
    for (int i = 0; i < NP; i++) begin
      drive(1, mk(1)); idle();
      chk("R2 grant order", int'(alloc_result), i);
    end
    chk("R2 pool full", int'(page_busy), 15);

    // R3 / R4: failure when full
    drive(1, mk(1)); idle();
    chk("R3 fail code", int'(alloc_result), 128);
    chk("R3 pending", int'(alloc_pending), 1);
    chk("R4 irq cleared", int'(irq_alloc), 0);

    // R5: release retries the pending allocation
    drive(0, 8'h00, 1, 2); idle();
    chk("R5 retry page", int'(alloc_result), 2);
    chk("R5 retry irq", int'(irq_alloc), 1);
    chk("R5 pending cleared", int'(alloc_pending), 0);

    // R5: release and allocate together, release first
    drive(1, mk(1), 1, 0); idle();
    chk("R5 same-cycle release", int'(alloc_result), 0);
    chk("R5 busy after", int'(page_busy), 15);

    // R9: fill receive queue and overflow
    drive(0, 8'h00, 0, 0, 1, 3); drive(0, 8'h00, 0, 0, 1, 1);
    drive(0, 8'h00, 0, 0, 1, 2); drive(0, 8'h00, 0, 0, 1, 0);
    drive(0, 8'h00, 0, 0, 1, 2); idle();
    chk("R9 rx full", int'(rx_count), 4);
    chk("R9 overflow", int'(rx_overflow), 1);
    chk("R7 irq_rx set", int'(irq_rx), 1);

    // R11: reserved and no-op codes
    drive(1, mk(5)); drive(1, mk(6)); drive(1, mk(7)); drive(1, mk(0)); idle();
    chk("R11 busy kept", int'(page_busy), 15);
    chk("R11 result kept", int'(alloc_result), 0);
    chk("R11 rx kept", int'(rx_count), 4);

    // R7: plain pop
    drive(1, mk(3)); idle();
    chk("R7 head shift", int'(rx_head), 1);
    chk("R7 count", int'(rx_count), 3);

    // R8: pop and free page 1
    drive(1, mk(4)); idle();
    chk("R8 freed page", int'(page_busy), 13);
    chk("R8 head", int'(rx_head), 2);

    // R7: drain and empty pop
    drive(1, mk(3)); drive(1, mk(3)); idle();
    chk("R7 empty", int'(rx_count), 0);
    chk("R7 irq_rx clear", int'(irq_rx), 0);
    drive(1, mk(3)); idle();
    chk("R7 empty pop ignored", int'(rx_count), 0);
    chk("R9 overflow sticky", int'(rx_overflow), 1);

    // R10: transmit-completion queue
    drive(0, 8'h00, 0, 0, 0, 0, 1, 1); drive(0, 8'h00, 0, 0, 0, 0, 1, 2);
    drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 1); idle();
    chk("R10 txd head", int'(txd_head), 2);
    drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 1); drive(0, 8'h00, 0, 0, 0, 0, 0, 0, 1); idle();
    chk("R10 empty pop ignored", int'(txd_count), 0);
    for (int i = 0; i < 5; i++) drive(0, 8'h00, 0, 0, 0, 0, 1, i);
    idle();
    chk("R10 full drop", int'(txd_count), 4);
    chk("R10 head kept", int'(txd_head), 0);

    // R6: MMU reset
    drive(1, mk(2), 0, 0, 1, 3, 1, 3); idle();
    chk("R6 busy clear", int'(page_busy), 0);
    chk("R6 txd clear", int'(txd_count), 0);
    chk("R6 rx clear", int'(rx_count), 0);
    chk("R6 overflow clear", int'(rx_overflow), 0);
    chk("R6 irq_alloc kept", int'(irq_alloc), 1);

    // Random phase, compared against the model every cycle
    for (int n = 0; n < 6000; n++) begin
      int r, opr, op;
      r = $urandom_range(0, 99);
      opr = $urandom_range(0, 99);
      op = (opr < 35) ? 1 : (opr < 55) ? 3 : (opr < 70) ? 4 : (opr < 72) ? 2 :
           (opr < 80) ? 5 + (opr % 3) : 0;
      drive(r < 45, {3'(op), 5'($urandom_range(0, 31))},
            $urandom_range(0, 99) < 20, $urandom_range(0, NP - 1),
            $urandom_range(0, 99) < 35, $urandom_range(0, NP - 1),
            $urandom_range(0, 99) < 35, $urandom_range(0, NP - 1),
            $urandom_range(0, 99) < 30);
    end
    idle();
    @(negedge clk);
    finish_run();
  end

endmodule